// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the floating-point status word of a processor core and decides what happens when a floating-point operation reports exceptions. On each operation-valid strobe it takes the raw exception vector from the arithmetic unit, an unimplemented-operand indication and the sign of the result. It then decides whether the pipeline must trap and drop the destination write, and it updates the per-operation cause bits, the accumulating sticky flags and the summary bit.

For masked overflow and masked divide-by-zero the block supplies a substitute result that the pipeline writes instead of the datapath value. The chosen rounding mode and the denormal-flush control are driven out continuously to the arithmetic unit. Software reads and writes the status word through a simple port. Cause bits can only be cleared by software, and the summary bit is computed.

Top module: `fpx_status_ctrl`

## Requirements
- R1: After reset the status word reads 0x00000100. Layout (bit 0 = LSB): rounding mode at 1:0; cause bits at 2..7 in the order invalid, overflow, divide-by-zero, underflow, inexact, unimplemented; denormal-flush at 8; enables at 10..14 in the order invalid, overflow, divide-by-zero, underflow, inexact; sticky flags at 26..30 in the same order; summary at 31. All other bits read 0.
- R2: The summary bit (31) is the OR of the invalid, overflow, divide-by-zero and underflow sticky flags and excludes the inexact flag. Software writes to it have no effect.
- R3: On every operation strobe all six cause bits are replaced by that operation's exceptions. The exception input `op_exc` uses bit 0 invalid, bit 1 overflow, bit 2 divide-by-zero, bit 3 underflow, bit 4 inexact. `op_unimpl` feeds the unimplemented cause bit.
- R4: A software write clears each cause bit written with 0. A 1 written to a cause bit leaves it unchanged.
- R5: A sticky flag is set when its exception occurs on an operation that does not trap. It stays set until software writes 0 to it.
- R6: `trap_req` and `wr_suppress` are high in the same cycle as the operation strobe when any exception has its enable set, or when `op_unimpl` is high, since that cause cannot be masked.
- R7: When enabled and masked exceptions occur together, the block traps and no sticky flag changes.
- R8: Masked overflow raises inexact as well. It substitutes the largest finite value of the result sign (0x7F7FFFFF / 0xFF7FFFFF) when rounding toward zero (01), toward +infinity (10) with a negative result, or toward -infinity (11) with a positive result. In every other case it substitutes infinity of that sign (0x7F800000 / 0xFF800000). Rounding mode 00 is round to nearest.
- R9: Masked divide-by-zero substitutes infinity carrying `op_sign`.
- R10: `rnd_mode` and `dn_flush` always show the rounding-mode and denormal-flush fields of the status word.
- R11: When a software write and an operation fall in the same cycle, the trap decision uses the enables from before the write. The control fields take the written value, and the cause bits take the operation's result. Each sticky flag becomes the written value ORed with the operation's sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One floating-point operation completes this cycle |
| op_exc | input | 5 | Raw exceptions of the operation |
| op_unimpl | input | 1 | Unimplemented-operand exception |
| op_sign | input | 1 | Sign of the operation's result |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current status word |
| trap_req | output | 1 | Take the floating-point trap |
| wr_suppress | output | 1 | Leave the destination register unchanged |
| subst_use | output | 1 | Write `subst_val` instead of the datapath result |
| subst_val | output | 32 | Substitute result for masked overflow or divide-by-zero |
| rnd_mode | output | 2 | Rounding mode to the datapath |
| dn_flush | output | 1 | Treat denormal operands as zero |

## Verification
The operation strobe and a software write can both land on the status word in the same cycle. The bench provokes this by asserting `sw_we` and `op_valid` together. First it writes enables that would have trapped the operation, and checks that no trap occurs because the enables in force before the write apply. In a second collision it writes zeros to the cause and sticky fields while an operation raises underflow. The word read back afterwards must show the written control fields, only the operation's cause bit, and the operation's sticky flag kept despite the clearing write.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int REG_W    = 32;
  localparam int EXC_N    = 5;
  localparam int CAUSE_N  = EXC_N + 1;
  localparam int RM_LO    = 0;
  localparam int CAUSE_LO = 2;
  localparam int DN_BIT   = 8;
  localparam int EN_LO    = 10;
  localparam int STK_LO   = 26;
  localparam int FS_BIT   = 31;
  localparam logic [REG_W-1:0] RESET_VAL = 32'h0000_0100;

  localparam int EX_V = 0;
  localparam int EX_O = 1;
  localparam int EX_Z = 2;
  localparam int EX_U = 3;
  localparam int EX_X = 4;

  localparam logic [REG_W-1:0] MAX_POS = 32'h7F7F_FFFF;
  localparam logic [REG_W-1:0] INF_POS = 32'h7F80_0000;

  typedef enum logic [1:0] {RND_NEAR = 2'b00, RND_ZERO = 2'b01,
                            RND_POS = 2'b10, RND_NEG = 2'b11} rnd_e;

  function automatic logic ovf_gives_max(input rnd_e rm, input logic sign);
    return (rm == RND_ZERO) || (rm == RND_POS && sign) || (rm == RND_NEG && !sign);
  endfunction

  function automatic logic [REG_W-1:0] signed_const(input logic [REG_W-1:0] mag,
                                                   input logic sign);
    return {sign, mag[REG_W-2:0]};
  endfunction
endpackage

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide
  import fpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [EXC_N-1:0]   exc_raw,
  input  logic               unimpl,
  input  logic [EXC_N-1:0]   enables,
  output logic               trap,
  output logic [EXC_N-1:0]   sticky_set,
  output logic [CAUSE_N-1:0] cause_new
);
  logic [EXC_N-1:0] exc_eff;
  logic [EXC_N-1:0] exc_enabled;
  logic             ovf_masked;

  always_comb begin
    ovf_masked        = exc_raw[EX_O] & ~enables[EX_O];
    exc_eff           = exc_raw;
    exc_eff[EX_X]     = exc_raw[EX_X] | ovf_masked;
    exc_enabled       = exc_eff & enables;
    trap              = op_valid & (unimpl | (|exc_enabled));
    sticky_set        = (op_valid && !trap) ? exc_eff : '0;
    cause_new         = {unimpl, exc_eff};
  end

  AST_UNIMPL_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && unimpl) |-> trap); // R6
endmodule

// File: rtl/fpx_subst_gen.sv
module fpx_subst_gen
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             trap,
  input  logic [EXC_N-1:0] exc_raw,
  input  logic [EXC_N-1:0] enables,
  input  rnd_e             rm,
  input  logic             sign,
  output logic             subst_use,
  output logic [REG_W-1:0] subst_val
);
  logic dz_masked;
  logic ovf_masked;

  always_comb begin
    dz_masked  = exc_raw[EX_Z] & ~enables[EX_Z];
    ovf_masked = exc_raw[EX_O] & ~enables[EX_O];
    subst_use  = op_valid & ~trap & (dz_masked | ovf_masked);
    if (dz_masked || !ovf_gives_max(rm, sign))
      subst_val = signed_const(INF_POS, sign);
    else
      subst_val = signed_const(MAX_POS, sign);
  end

  AST_SUBST_NEVER_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    subst_use |-> !trap); // R8
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [CAUSE_N-1:0] cause_new,
  input  logic [EXC_N-1:0]   sticky_set,
  input  logic               sw_we,
  input  logic [REG_W-1:0]   sw_wdata,
  output rnd_e               rm,
  output logic               dn,
  output logic [EXC_N-1:0]   enables,
  output logic [CAUSE_N-1:0] cause,
  output logic [EXC_N-1:0]   sticky
);
  logic [CAUSE_N-1:0] wd_cause;
  logic [EXC_N-1:0]   wd_en;
  logic [EXC_N-1:0]   wd_stk;
  logic [EXC_N-1:0]   stk_nxt;
  logic [CAUSE_N-1:0] cause_nxt;
  logic               unused_wbits;

  assign wd_cause     = sw_wdata[CAUSE_LO +: CAUSE_N];
  assign wd_en        = sw_wdata[EN_LO +: EXC_N];
  assign wd_stk       = sw_wdata[STK_LO +: EXC_N];
  assign unused_wbits = ^{sw_wdata[DN_BIT+1], sw_wdata[STK_LO-1:EN_LO+EXC_N], sw_wdata[FS_BIT]};

  for (genvar i = 0; i < EXC_N; i++) begin : g_stk
    assign stk_nxt[i] = (sw_we ? wd_stk[i] : sticky[i]) | sticky_set[i];
  end

  always_comb begin
    if (op_valid)   cause_nxt = cause_new;
    else if (sw_we) cause_nxt = cause & wd_cause;
    else            cause_nxt = cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm      <= rnd_e'(RESET_VAL[RM_LO +: 2]);
      dn      <= RESET_VAL[DN_BIT];
      enables <= RESET_VAL[EN_LO +: EXC_N];
      cause   <= RESET_VAL[CAUSE_LO +: CAUSE_N];
      sticky  <= RESET_VAL[STK_LO +: EXC_N];
    end else begin
      if (sw_we) begin
        rm      <= rnd_e'(sw_wdata[RM_LO +: 2]);
        dn      <= sw_wdata[DN_BIT];
        enables <= wd_en;
      end
      cause  <= cause_nxt;
      sticky <= stk_nxt;
    end
  end

  AST_CAUSE_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ((cause & ~$past(cause)) == '0)); // R4
endmodule

// File: rtl/fpx_status_ctrl.sv
module fpx_status_ctrl
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [4:0]       op_exc,
  input  logic             op_unimpl,
  input  logic             op_sign,
  input  logic             sw_we,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  output logic             trap_req,
  output logic             wr_suppress,
  output logic             subst_use,
  output logic [31:0]      subst_val,
  output logic [1:0]       rnd_mode,
  output logic             dn_flush
);
  rnd_e               rm;
  logic               dn;
  logic [EXC_N-1:0]   enables;
  logic [CAUSE_N-1:0] cause;
  logic [EXC_N-1:0]   sticky;
  logic [CAUSE_N-1:0] cause_new;
  logic [EXC_N-1:0]   sticky_set;
  logic               trap;
  logic               summary;

  fpx_trap_decide u_decide (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .exc_raw(op_exc),
    .unimpl(op_unimpl), .enables(enables), .trap(trap),
    .sticky_set(sticky_set), .cause_new(cause_new));

  fpx_subst_gen u_subst (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .trap(trap),
    .exc_raw(op_exc), .enables(enables), .rm(rm), .sign(op_sign),
    .subst_use(subst_use), .subst_val(subst_val));

  fpx_status_reg u_reg (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cause_new(cause_new),
    .sticky_set(sticky_set), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .rm(rm), .dn(dn), .enables(enables), .cause(cause), .sticky(sticky));

  always_comb begin
    summary = sticky[EX_V] | sticky[EX_O] | sticky[EX_Z] | sticky[EX_U];
    sw_rdata = '0;
    sw_rdata[RM_LO +: 2]          = rm;
    sw_rdata[CAUSE_LO +: CAUSE_N] = cause;
    sw_rdata[DN_BIT]              = dn;
    sw_rdata[EN_LO +: EXC_N]      = enables;
    sw_rdata[STK_LO +: EXC_N]     = sticky;
    sw_rdata[FS_BIT]              = summary;
  end

  assign trap_req    = trap;
  assign wr_suppress = trap;
  assign rnd_mode    = rm;
  assign dn_flush    = dn;

  AST_FS_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[FS_BIT] == (|sw_rdata[STK_LO+EX_U:STK_LO])); // R2

  AST_STICKY_FROZEN_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !sw_we) |=> $stable(sw_rdata[STK_LO +: EXC_N])); // R7

  AST_OVF_MASKED_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !trap_req && op_exc[EX_O]) |=> sw_rdata[STK_LO+EX_X]); // R8
endmodule

// File: tb/fpx_status_ctrl_bench.sv
`timescale 1ns/1ps
module fpx_status_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_exc = '0;
  logic        op_unimpl = 1'b0;
  logic        op_sign = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        trap_req, wr_suppress, subst_use, dn_flush;
  logic [31:0] subst_val;
  logic [1:0]  rnd_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic        s_trap, s_sup, s_use;
  logic [31:0] s_val;

  always #4 clk = ~clk;

  fpx_status_ctrl u_fpx_status_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
    .op_unimpl(op_unimpl), .op_sign(op_sign), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .trap_req(trap_req), .wr_suppress(wr_suppress),
    .subst_use(subst_use), .subst_val(subst_val), .rnd_mode(rnd_mode),
    .dn_flush(dn_flush));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; combinational outputs captured mid-cycle,
  // registered state visible after the following edge
  task automatic step(input logic op, input logic [4:0] ex, input logic un,
                      input logic sg, input logic we, input logic [31:0] wd);
    @(negedge clk);
    op_valid = op; op_exc = ex; op_unimpl = un; op_sign = sg;
    sw_we = we; sw_wdata = wd;
    #1;
    s_trap = trap_req; s_sup = wr_suppress; s_use = subst_use; s_val = subst_val;
    @(negedge clk);
    op_valid = 0; op_exc = '0; op_unimpl = 0; op_sign = 0; sw_we = 0; sw_wdata = '0;
    #1;
  endtask

  task automatic wr(input logic [31:0] wd);
    step(0, 5'b0, 0, 0, 1, wd);
  endtask

  task automatic t_reset;
    chk("R1 reset word", sw_rdata, 32'h0000_0100);
    chk("R10 reset rnd_mode", {30'b0, rnd_mode}, 32'h0);
    chk("R10 reset dn_flush", {31'b0, dn_flush}, 32'h1);
    chk("R6 reset no trap", {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_inexact_and_cause;
    step(1, 5'b10000, 0, 0, 0, 32'h0);
    chk("R6 masked inexact no trap", {31'b0, s_trap}, 32'h0);
    chk("R2 R5 inexact sticky, summary stays 0", sw_rdata, 32'h4000_0140);
    step(1, 5'b00001, 0, 0, 0, 32'h0);
    chk("R3 cause replaced, R2 summary set", sw_rdata, 32'hC400_0104);
  endtask

  task automatic t_sw_cause;
    wr(32'h4400_01FC);
    chk("R4 writing 1 to cause has no effect", sw_rdata, 32'hC400_0104);
    wr(32'h4400_0100);
    chk("R4 writing 0 clears cause", sw_rdata, 32'hC400_0100);
    wr(32'h8000_0100);
    chk("R5 R2 sticky cleared by software, summary ignores write", sw_rdata, 32'h0000_0100);
  endtask

  task automatic t_trap;
    wr(32'h0000_1100);
    step(1, 5'b00100, 0, 1, 0, 32'h0);
    chk("R6 enabled div0 traps", {29'b0, s_trap, s_sup, s_use}, 32'h6);
    chk("R6 trap sets cause only", sw_rdata, 32'h0000_1110);
    wr(32'h0000_0100);
    step(1, 5'b00000, 1, 0, 0, 32'h0);
    chk("R6 unimplemented traps unmasked", {30'b0, s_trap, s_sup}, 32'h3);
    chk("R3 unimplemented cause bit", sw_rdata, 32'h0000_0180);
  endtask

  task automatic t_mixed;
    wr(32'h0000_0500);
    step(1, 5'b01001, 0, 0, 0, 32'h0);
    chk("R7 mixed enabled/masked traps", {31'b0, s_trap}, 32'h1);
    chk("R7 mixed leaves sticky unchanged", sw_rdata, 32'h0000_0524);
  endtask

  task automatic t_overflow;
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < 2; s++) begin
        logic        use_max;
        logic [31:0] exp_val;
        wr(32'h0000_0100 | r);
        chk("R10 rnd_mode follows word", {30'b0, rnd_mode}, r);
        step(1, 5'b00010, 0, s[0], 0, 32'h0);
        use_max = (r == 1) || (r == 2 && s == 1) || (r == 3 && s == 0);
        exp_val = use_max ? (s ? 32'hFF7F_FFFF : 32'h7F7F_FFFF)
                          : (s ? 32'hFF80_0000 : 32'h7F80_0000);
        chk("R8 masked overflow substitute used", {31'b0, s_use}, 32'h1);
        chk("R8 masked overflow value", s_val, exp_val);
        chk("R8 overflow raises inexact", sw_rdata, 32'hC800_0148 | r);
      end
    end
    wr(32'h0000_4100);
    step(1, 5'b00010, 0, 0, 0, 32'h0);
    chk("R8 R7 masked overflow with inexact enabled traps", {30'b0, s_trap, s_use}, 32'h2);
    chk("R8 trap keeps sticky clear", sw_rdata, 32'h0000_4148);
  endtask

  task automatic t_div0;
    wr(32'h0000_0100);
    step(1, 5'b00100, 0, 1, 0, 32'h0);
    chk("R9 masked div0 negative infinity", s_val, 32'hFF80_0000);
    chk("R9 masked div0 substitute used", {31'b0, s_use}, 32'h1);
    step(1, 5'b00100, 0, 0, 0, 32'h0);
    chk("R9 masked div0 positive infinity", s_val, 32'h7F80_0000);
    chk("R5 div0 sticky", sw_rdata, 32'h9000_0110);
  endtask

  task automatic t_dn;
    wr(32'h0000_0000);
    chk("R10 dn_flush cleared", {31'b0, dn_flush}, 32'h0);
    chk("R1 word all zero", sw_rdata, 32'h0);
  endtask

  task automatic t_same_cycle;
    wr(32'h0000_0100);
    step(1, 5'b00001, 0, 0, 1, 32'h0000_0402);
    chk("R11 old enables decide trap", {31'b0, s_trap}, 32'h0);
    chk("R11 write plus operation merge", sw_rdata, 32'h8400_0406);
    step(1, 5'b01000, 0, 0, 1, 32'h0000_0402);
    chk("R11 sticky kept over clearing write", sw_rdata, 32'hA000_0422);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_inexact_and_cause();
    t_sw_cause();
    t_trap();
    t_mixed();
    t_overflow();
    t_div0();
    t_dn();
    t_same_cycle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule